// File: doc/BRIEF.md
# Write-Posting Buffer with Read Priority

This block sits between a write-through cache and a single shared memory port. Processor stores (word address, data, byte enables) go into a small first-in, first-out queue and are acknowledged at once, so the processor does not wait for memory. Buffered stores are retired to memory lazily, only in cycles when no read needs the port. Reads are served before writes, which keeps read latency short.

A read that would miss in the cache is checked against every buffered store to the same word address. If the matching stores together write every byte of the word, the read is answered from the buffer: older entries are applied first and younger ones override them byte by byte. If only some bytes are covered, the read is held until those stores have drained and is then sent to memory. The memory side is a valid/ready request channel with a write-enable flag and a separate read-response strobe. At most one memory read is outstanding. Addresses are word addresses.

Top module: `wr_post_buf`

## Requirements
- R1: After reset the buffer is empty (`empty_o`=1, `full_o`=0), `cpu_wr_ready_o` is 1 and no memory request is raised while no read is presented.
- R2: Buffered stores reach the memory port in the order they were accepted. The request shows the oldest entry's address, data and byte enables.
- R3: A store is accepted in the cycle it is presented whenever the buffer is not full. `cpu_wr_ready_o` is 0 only while all DEPTH entries are occupied and no drain completes that cycle.
- R4: A read that needs memory takes the port in the same cycle (`mem_req_we_o`=0, `mem_req_addr_o` = read address), even when stores are waiting.
- R5: Stores drain only in cycles with no read request on the port. An entry leaves the buffer only in a cycle where `mem_req_valid_o`, `mem_req_we_o` and `mem_req_ready_i` are all 1.
- R6: A read whose matching entries cover all byte enables is accepted in the cycle it is presented and is answered one cycle later with no memory read. The data merges the matching entries oldest to youngest, bit `b` of a byte-enable selecting bits `8b+7:8b`.
- R7: A read that matches buffered stores without covering every byte keeps `cpu_rd_ready_o` at 0 and issues no memory read until those entries have drained.
- R8: When the buffer is full and the head drains in the same cycle that a store is presented, the store is accepted and the buffer stays full.
- R9: `full_o` and `empty_o` are registered and reflect an occupancy of DEPTH and 0 entries respectively.
- R10: A read sent to memory returns `mem_rsp_data_i` on `cpu_rd_resp_data_o` one cycle after `mem_rsp_valid_i`. No second read is accepted until the response arrives, but stores keep draining in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_valid_i | input | 1 | Store presented |
| cpu_wr_ready_o | output | 1 | Store accepted this cycle |
| cpu_wr_addr_i | input | AW | Store word address |
| cpu_wr_data_i | input | DW | Store data |
| cpu_wr_be_i | input | DW/8 | Store byte enables |
| cpu_rd_valid_i | input | 1 | Read presented |
| cpu_rd_ready_o | output | 1 | Read accepted this cycle |
| cpu_rd_addr_i | input | AW | Read word address |
| cpu_rd_resp_valid_o | output | 1 | Read data valid |
| cpu_rd_resp_data_o | output | DW | Read data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 for a store, 0 for a read |
| mem_req_addr_o | output | AW | Request word address |
| mem_req_data_o | output | DW | Store data |
| mem_req_be_o | output | DW/8 | Store byte enables, all ones on a read |
| mem_rsp_valid_i | input | 1 | Memory read response valid |
| mem_rsp_data_i | input | DW | Memory read response data |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entry occupied |

## Verification
Some properties are checked on every cycle: the queue never overflows or underflows, the flags change only with a real push or pop, a read that needs memory always wins the port, and only one read is ever outstanding. The same holds for answering a covered read locally with a response in the next cycle, holding back a partly covered read, and keeping the buffer full when a swap happens at full occupancy. Only the bench's scenarios against a memory stub can show end-to-end effects. These are the drain order, byte-accurate merging of several stores, correct memory contents after a partial hit has drained, and read data matching the program order of the stores.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_RD   = 2'd1,
    GNT_WR   = 2'd2
  } gnt_e;

  function automatic int unsigned ptr_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned BW    = DW / 8,
  parameter int unsigned PW    = wpb_pkg::ptr_w(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [BW-1:0] push_be_i,
  input  logic          pop_i,
  output logic [AW-1:0] ent_addr_o [DEPTH],
  output logic [DW-1:0] ent_data_o [DEPTH],
  output logic [BW-1:0] ent_be_o   [DEPTH],
  output logic [PW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [BW-1:0] head_be_o
);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [BW-1:0] be_q   [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, count_d;
  logic          full_q, empty_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        data_q[g] <= '0;
        be_q[g]   <= '0;
      end else if (push_i && wr_ptr_q == PW'(g)) begin
        addr_q[g] <= push_addr_i;
        data_q[g] <= push_data_i;
        be_q[g]   <= push_be_i;
      end
    end
  end

  always_comb begin
    count_d = count_q;
    if (push_i && !pop_i)      count_d = count_q + 1'b1;
    else if (!push_i && pop_i) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      count_q <= count_d;
      full_q  <= (count_d == CW'(DEPTH));
      empty_q <= (count_d == '0);
    end
  end

  assign ent_addr_o  = addr_q;
  assign ent_data_o  = data_q;
  assign ent_be_o    = be_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign count_o     = count_q;
  assign full_o      = full_q;
  assign empty_o     = empty_q;
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign head_be_o   = be_q[rd_ptr_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_q |-> pop_i); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_q); // R5
  AST_FULL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(push_i && !pop_i)); // R9
  AST_EMPTY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_q) |-> $past(pop_i && !push_i)); // R9

endmodule

// File: rtl/wpb_fwd.sv
module wpb_fwd #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned BW    = DW / 8,
  parameter int unsigned PW    = wpb_pkg::ptr_w(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] ent_addr_i [DEPTH],
  input  logic [DW-1:0] ent_data_i [DEPTH],
  input  logic [BW-1:0] ent_be_i   [DEPTH],
  input  logic [PW-1:0] rd_ptr_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          hit_o,
  output logic          cover_all_o,
  output logic [DW-1:0] data_o
);

  function automatic logic [PW-1:0] age_slot(input logic [PW-1:0] base,
                                             input int unsigned   k);
    int unsigned s;
    s = 32'(base) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return s[PW-1:0];
  endfunction

  // Oldest to youngest so that younger byte lanes override older ones.
  always_comb begin
    logic [PW-1:0] idx;
    logic [BW-1:0] cov;
    idx    = '0;
    cov    = '0;
    hit_o  = 1'b0;
    data_o = '0;
    for (int unsigned k = 0; k < DEPTH; k++) begin
      idx = age_slot(rd_ptr_i, k);
      if (k < 32'(count_i) && ent_addr_i[idx] == rd_addr_i) begin
        hit_o = 1'b1;
        for (int unsigned b = 0; b < BW; b++) begin
          if (ent_be_i[idx][b]) begin
            data_o[b*8 +: 8] = ent_data_i[idx][b*8 +: 8];
            cov[b]           = 1'b1;
          end
        end
      end
    end
    cover_all_o = hit_o && (&cov);
  end

endmodule

// File: rtl/wpb_arb.sv
module wpb_arb
  import wpb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_need_i,
  input  logic wr_pend_i,
  input  logic mem_ready_i,
  output gnt_e gnt_o,
  output logic rd_fire_o,
  output logic drain_fire_o
);

  always_comb begin
    if (rd_need_i)      gnt_o = GNT_RD;
    else if (wr_pend_i) gnt_o = GNT_WR;
    else                gnt_o = GNT_NONE;
  end

  assign rd_fire_o    = (gnt_o == GNT_RD) && mem_ready_i;
  assign drain_fire_o = (gnt_o == GNT_WR) && mem_ready_i;

  AST_DRAIN_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_fire_o |-> !rd_need_i && mem_ready_i && wr_pend_i); // R5

endmodule

// File: rtl/wr_post_buf.sv
module wr_post_buf
  import wpb_pkg::*;
#(
  parameter  int unsigned DEPTH = 4,
  parameter  int unsigned AW    = 32,
  parameter  int unsigned DW    = 32,
  localparam int unsigned BW    = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_wr_valid_i,
  output logic          cpu_wr_ready_o,
  input  logic [AW-1:0] cpu_wr_addr_i,
  input  logic [DW-1:0] cpu_wr_data_i,
  input  logic [BW-1:0] cpu_wr_be_i,
  input  logic          cpu_rd_valid_i,
  output logic          cpu_rd_ready_o,
  input  logic [AW-1:0] cpu_rd_addr_i,
  output logic          cpu_rd_resp_valid_o,
  output logic [DW-1:0] cpu_rd_resp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_data_o,
  output logic [BW-1:0] mem_req_be_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          full_o,
  output logic          empty_o
);

  localparam int unsigned PW = ptr_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [BW-1:0] ent_be   [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [BW-1:0] head_be;
  logic          full, empty, push, pop;
  logic          fwd_hit, fwd_all;
  logic [DW-1:0] fwd_data;
  logic          rd_busy_q, rd_need, rd_fwd, rd_mem_fire;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;
  gnt_e          gnt;

  wpb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PW(PW), .CW(CW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (cpu_wr_addr_i),
    .push_data_i (cpu_wr_data_i),
    .push_be_i   (cpu_wr_be_i),
    .pop_i       (pop),
    .ent_addr_o  (ent_addr),
    .ent_data_o  (ent_data),
    .ent_be_o    (ent_be),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (head_addr),
    .head_data_o (head_data),
    .head_be_o   (head_be)
  );

  wpb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW), .PW(PW), .CW(CW)) u_fwd (
    .ent_addr_i  (ent_addr),
    .ent_data_i  (ent_data),
    .ent_be_i    (ent_be),
    .rd_ptr_i    (rd_ptr),
    .count_i     (count),
    .rd_addr_i   (cpu_rd_addr_i),
    .hit_o       (fwd_hit),
    .cover_all_o (fwd_all),
    .data_o      (fwd_data)
  );

  // Any address match keeps the read off the port; partial matches wait for drain.
  assign rd_need = cpu_rd_valid_i && !rd_busy_q && !fwd_hit;
  assign rd_fwd  = cpu_rd_valid_i && !rd_busy_q && fwd_all;

  wpb_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_need_i    (rd_need),
    .wr_pend_i    (!empty),
    .mem_ready_i  (mem_req_ready_i),
    .gnt_o        (gnt),
    .rd_fire_o    (rd_mem_fire),
    .drain_fire_o (pop)
  );

  assign cpu_wr_ready_o = !full || pop;
  assign push           = cpu_wr_valid_i && cpu_wr_ready_o;
  assign cpu_rd_ready_o = rd_fwd || rd_mem_fire;

  assign mem_req_valid_o = (gnt != GNT_NONE);
  assign mem_req_we_o    = (gnt == GNT_WR);
  assign mem_req_addr_o  = (gnt == GNT_WR) ? head_addr : cpu_rd_addr_i;
  assign mem_req_data_o  = head_data;
  assign mem_req_be_o    = (gnt == GNT_WR) ? head_be : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rd_mem_fire)          rd_busy_q <= 1'b1;
      else if (mem_rsp_valid_i) rd_busy_q <= 1'b0;
      rsp_valid_q <= rd_fwd || (rd_busy_q && mem_rsp_valid_i);
      if (rd_fwd)                             rsp_data_q <= fwd_data;
      else if (rd_busy_q && mem_rsp_valid_i)  rsp_data_q <= mem_rsp_data_i;
    end
  end

  assign cpu_rd_resp_valid_o = rsp_valid_q;
  assign cpu_rd_resp_data_o  = rsp_data_q;
  assign full_o              = full;
  assign empty_o             = empty;

  AST_READ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_valid_i && !rd_busy_q && !fwd_hit |-> mem_req_valid_o && !mem_req_we_o); // R4
  AST_FWD_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fwd |-> !(mem_req_valid_o && !mem_req_we_o) && cpu_rd_ready_o); // R6
  AST_FWD_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fwd |=> cpu_rd_resp_valid_o); // R6
  AST_PARTIAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_valid_i && fwd_hit && !fwd_all |-> !cpu_rd_ready_o && !(mem_req_valid_o && !mem_req_we_o)); // R7
  AST_FULL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && pop && cpu_wr_valid_i |=> full_o); // R8
  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_q |-> !(mem_req_valid_o && !mem_req_we_o) && !cpu_rd_ready_o); // R10

endmodule

// File: tb/test_wr_post_buf.sv
module test_wr_post_buf;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b1;
  logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [3:0]  wr_be = '0;
  logic        cpu_wr_ready_o, cpu_rd_ready_o, cpu_rd_resp_valid_o;
  logic [31:0] cpu_rd_resp_data_o;
  logic        mem_req_valid_o, mem_req_we_o;
  logic [31:0] mem_req_addr_o, mem_req_data_o;
  logic [3:0]  mem_req_be_o;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        full_o, empty_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wr_post_buf #(.DEPTH(DEPTH), .AW(32), .DW(32)) i_wr_post_buf (
    .clk_i               (clk),
    .rst_ni              (rst_n),
    .cpu_wr_valid_i      (wr_valid),
    .cpu_wr_ready_o      (cpu_wr_ready_o),
    .cpu_wr_addr_i       (wr_addr),
    .cpu_wr_data_i       (wr_data),
    .cpu_wr_be_i         (wr_be),
    .cpu_rd_valid_i      (rd_valid),
    .cpu_rd_ready_o      (cpu_rd_ready_o),
    .cpu_rd_addr_i       (rd_addr),
    .cpu_rd_resp_valid_o (cpu_rd_resp_valid_o),
    .cpu_rd_resp_data_o  (cpu_rd_resp_data_o),
    .mem_req_valid_o     (mem_req_valid_o),
    .mem_req_ready_i     (mem_ready),
    .mem_req_we_o        (mem_req_we_o),
    .mem_req_addr_o      (mem_req_addr_o),
    .mem_req_data_o      (mem_req_data_o),
    .mem_req_be_o        (mem_req_be_o),
    .mem_rsp_valid_i     (mem_rsp_valid),
    .mem_rsp_data_i      (mem_rsp_data),
    .full_o              (full_o),
    .empty_o             (empty_o)
  );

  // Memory stub: 16 words, read answered three cycles after acceptance.
  logic [31:0] smem [16];
  logic [31:0] drain_log [32];
  int          drain_n = 0;
  int          rd_req_n = 0;
  logic        stub_pend;
  logic [1:0]  stub_cnt;
  logic [31:0] stub_dat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) smem[i] <= 32'hA000_0000 + 32'(i);
      stub_pend     <= 1'b0;
      stub_cnt      <= '0;
      stub_dat      <= '0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid_o && mem_ready) begin
        if (mem_req_we_o) begin
          for (int b = 0; b < 4; b++)
            if (mem_req_be_o[b]) smem[mem_req_addr_o[3:0]][b*8 +: 8] <= mem_req_data_o[b*8 +: 8];
          drain_log[drain_n[4:0]] <= mem_req_addr_o;
          drain_n <= drain_n + 1;
        end else begin
          stub_pend <= 1'b1;
          stub_cnt  <= 2'd2;
          stub_dat  <= smem[mem_req_addr_o[3:0]];
          rd_req_n  <= rd_req_n + 1;
        end
      end
      if (stub_pend) begin
        if (stub_cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= stub_dat;
          stub_pend     <= 1'b0;
        end else begin
          stub_cnt <= stub_cnt - 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                    output int stall);
    stall = 0;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    forever begin
      #1;
      if (cpu_wr_ready_o) break;
      stall++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic rd_start(input logic [31:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
  endtask

  // Call at a falling edge.
  task automatic rd_finish(output logic [31:0] d, output int stall, output int lat);
    stall = 0;
    forever begin
      #1;
      if (cpu_rd_ready_o) break;
      stall++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 rd_valid = 1'b0;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (cpu_rd_resp_valid_o || lat > 40) break;
    end
    d = cpu_rd_resp_data_o;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (empty_o) break;
    end
  endtask

  typedef struct packed {
    logic        is_rd;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'd1,  32'h1111_1111, 4'hF, 32'h0},
    '{1'b0, 32'd2,  32'h2222_2222, 4'hF, 32'h0},
    '{1'b1, 32'd1,  32'h0,         4'h0, 32'h1111_1111},
    '{1'b0, 32'd1,  32'h0000_AB00, 4'h2, 32'h0},
    '{1'b1, 32'd1,  32'h0,         4'h0, 32'h1111_AB11},
    '{1'b1, 32'd3,  32'h0,         4'h0, 32'hA000_0003},
    '{1'b0, 32'd3,  32'hCC00_0000, 4'h8, 32'h0},
    '{1'b0, 32'd3,  32'h0000_00DD, 4'h1, 32'h0},
    '{1'b1, 32'd3,  32'h0,         4'h0, 32'hCC00_00DD},
    '{1'b1, 32'd2,  32'h0,         4'h0, 32'h2222_2222},
    '{1'b0, 32'd15, 32'hDEAD_BEEF, 4'hF, 32'h0},
    '{1'b1, 32'd15, 32'h0,         4'h0, 32'hDEAD_BEEF},
    '{1'b1, 32'd0,  32'h0,         4'h0, 32'hA000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int          st, lat, base, rq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 / R9 reset state
    chk("R1 empty", 32'(empty_o), 32'd1);
    chk("R1 full", 32'(full_o), 32'd0);
    chk("R1 no request", 32'(mem_req_valid_o), 32'd0);
    chk("R1 wr ready", 32'(cpu_wr_ready_o), 32'd1);

    // Vector table: program-order reads with memory always ready (R10, R6, R2)
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].is_rd) begin
        rd_start(VECS[i].addr);
        rd_finish(d, st, lat);
        chk($sformatf("R10 vec%0d read", i), d, VECS[i].exp);
      end else begin
        wr(VECS[i].addr, VECS[i].data, VECS[i].be, st);
        chk($sformatf("R3 vec%0d accept", i), 32'(st), 32'd0);
      end
    end
    wait_empty();

    // Fill with memory stalled: R3, R9, R2
    mem_ready = 1'b0;
    base = drain_n;
    for (int i = 0; i < DEPTH; i++) begin
      wr(32'd8 + 32'(i), 32'h8000_0000 + 32'(i), 4'hF, st);
      chk("R3 accept while not full", 32'(st), 32'd0);
    end
    @(negedge clk); #1;
    chk("R9 full flag", 32'(full_o), 32'd1);
    chk("R9 empty flag", 32'(empty_o), 32'd0);
    chk("R3 stall when full", 32'(cpu_wr_ready_o), 32'd0);
    chk("R2 head on port", mem_req_addr_o, 32'd8);
    chk("R2 head is store", 32'(mem_req_valid_o && mem_req_we_o), 32'd1);

    // R8 swap at full
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 32'd12; wr_data = 32'hC0DE_0012; wr_be = 4'hF;
    mem_ready = 1'b1;
    #1 chk("R8 accept on drain", 32'(cpu_wr_ready_o), 32'd1);
    @(posedge clk);
    #1 begin wr_valid = 1'b0; mem_ready = 1'b0; end
    @(negedge clk); #1;
    chk("R8 still full", 32'(full_o), 32'd1);
    chk("R2 next head", mem_req_addr_o, 32'd9);
    @(negedge clk);
    mem_ready = 1'b1;
    wait_empty();
    for (int i = 0; i < 5; i++)
      chk("R2 drain order", drain_log[5'(base + i)], 32'd8 + 32'(i));
    chk("R5 idle when empty", 32'(mem_req_valid_o), 32'd0);

    // R4 read priority over a waiting store
    mem_ready = 1'b0;
    wr(32'd4, 32'h4444_4444, 4'hF, st);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 32'd13; mem_ready = 1'b1;
    #1;
    chk("R4 read on port", 32'(mem_req_valid_o && !mem_req_we_o), 32'd1);
    chk("R4 read address", mem_req_addr_o, 32'd13);
    chk("R4 read accepted", 32'(cpu_rd_ready_o), 32'd1);
    @(posedge clk);
    #1 rd_valid = 1'b0;
    @(negedge clk); #1;
    chk("R10 drain while read waits", 32'(mem_req_valid_o && mem_req_we_o), 32'd1);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (cpu_rd_resp_valid_o || lat > 40) break;
    end
    chk("R10 memory data", cpu_rd_resp_data_o, 32'hA000_000D);
    wait_empty();

    // R6 forwarding merged from three stores
    mem_ready = 1'b0;
    wr(32'd6, 32'h0000_1234, 4'h3, st);
    wr(32'd6, 32'h5678_0000, 4'hC, st);
    wr(32'd6, 32'h0000_00FF, 4'h1, st);
    rq = rd_req_n;
    rd_start(32'd6);
    rd_finish(d, st, lat);
    chk("R6 merged data", d, 32'h5678_12FF);
    chk("R6 no stall", 32'(st), 32'd0);
    chk("R6 next-cycle response", 32'(lat), 32'd1);
    chk("R6 no memory read", 32'(rd_req_n), 32'(rq));
    mem_ready = 1'b1;
    wait_empty();
    rd_start(32'd6);
    rd_finish(d, st, lat);
    chk("R2 memory after drain", d, 32'h5678_12FF);

    // R7 partial cover holds the read
    mem_ready = 1'b0;
    wr(32'd7, 32'h0000_00EE, 4'h1, st);
    rq = rd_req_n;
    rd_start(32'd7);
    #1;
    chk("R7 held", 32'(cpu_rd_ready_o), 32'd0);
    chk("R7 no read issued", 32'(mem_req_valid_o && !mem_req_we_o), 32'd0);
    @(negedge clk); #1;
    chk("R7 still held", 32'(cpu_rd_ready_o), 32'd0);
    @(negedge clk);
    mem_ready = 1'b1;
    #1 chk("R5 store drains first", 32'(mem_req_valid_o && mem_req_we_o), 32'd1);
    @(negedge clk);
    rd_finish(d, st, lat);
    chk("R7 merged from memory", d, 32'hA000_00EE);
    chk("R7 one memory read", 32'(rd_req_n), 32'(rq + 1));
    @(negedge clk); #1;
    chk("R9 empty at end", 32'(empty_o), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule